// File: doc/BRIEF.md
# Acquisition Sequencer with Host Register Port

This block is the control state machine for a capture-and-readout path. A capture front end fills a bulk memory, a mover copies the stored data back out into an output FIFO, and a host fetches it from that FIFO. The sequencer starts the capture and enables the outbound mover. It waits for each stage to report completion and raises interrupts at the milestones. The host drives it through a synchronous 32-bit register port with an address, a write strobe and a data word. Reads are combinational from the address. There are five write-only registers and two read-only registers.

The machine steps through seven states: idle, capture, inbound transfer, read request, FIFO ready, drain and done. Leaving idle needs three things together: the memory reports that it is initialised, the host has set the start bit, and a rising edge arrives on the synchronised hard-start pin. The host must then ask for readout and acknowledge the FIFO-ready condition before the sequence can finish. The host acknowledge and the outbound-done indication may arrive in either order. Interrupt causes latch into a pending register. The interrupt line stays high until the host clears the cause. The block has no data stream, so every pin is a plain control or status level or pulse.

Register map (addresses on `reg_addr`):
- 0, control, write 1 to set: bit0 start, bit1 read request, bit2 drain acknowledge.
- 1, interrupt enable: bit1 inbound done, bit2 FIFO ready, bit3 sequence done.
- 2, interrupt clear: a 1 clears the matching pending bit.
- 3, requested sample count.
- 4, FIFO-ready level threshold. It resets to 64.
- 5, status, read-only: [2:0] state code, bit3 capture enable, bit4 outbound enable, bit5 FIFO-ready flag, [11:8] pending causes, bit12 memory ready.
- 6, latched sample count, read-only.

State codes: 0 idle, 1 capture, 2 inbound transfer, 3 read request, 4 FIFO ready, 5 drain, 6 done. Pending bit0 records a forced stop.

Top module: `acq_seq_ctrl`

## Requirements
- R1: After reset, `cap_en`, `outb_en` and `irq` are 0 and the status register reads state code 0 (idle).
- R2: The machine leaves idle for capture, with `cap_en` high, only when `mem_ready` is 1, control bit0 is set, and a rising edge of `hard_start` appears after its two-stage synchroniser. A rising edge seen while `mem_ready` is 0 is lost. A later `mem_ready` with no new edge does not start a capture.
- R3: In capture, `cap_done` moves the machine to the inbound-transfer state and `cap_en` drops on the next clock. If `cap_forced` is high at that cycle, pending bit0 is set whatever the enables hold.
- R4: In inbound transfer, `inb_done` moves the machine to read request. Pending bit1 is set only when enable bit1 is 1.
- R5: In read request, setting control bit1 moves the machine to FIFO ready and raises `outb_en`. The latched count (address 6) follows the requested count (address 3) while the machine is in read request.
- R6: In FIFO ready, once `ofifo_level` is at least the threshold (address 4, reset 64), the machine moves to drain, sets status bit5, and sets pending bit2 if enable bit2 is 1. A level one below the threshold keeps it waiting.
- R7: `outb_done` while `outb_en` is high drops `outb_en` on the next clock. The machine leaves drain for done only once both control bit2 and an outbound done (earlier or in the same cycle) have been seen, in either order.
- R8: In done, the machine returns to idle when `fetched_cnt` is at least the latched count. Pending bit3 is set if enable bit3 is 1.
- R9: The status register reloads on every clock except while the machine is in read request, where it holds its value.
- R10: `irq` is high exactly while any pending bit is set. It stays high until the host writes 1 to that bit at address 2.
- R11: Control bits 0, 1 and 2 clear themselves when the state that consumes them is left. A new `hard_start` edge after a finished sequence does not start another capture.
- R12: Reads of the write-only addresses 0 to 4 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| mem_ready | input | 1 | Bulk memory initialised |
| hard_start | input | 1 | Asynchronous hard-start pin |
| cap_done | input | 1 | Capture finished (pulse) |
| cap_forced | input | 1 | Capture ended by forced stop, valid with `cap_done` |
| inb_done | input | 1 | Inbound transfer finished (pulse) |
| outb_done | input | 1 | Outbound transfer finished (pulse) |
| ofifo_level | input | 12 | Output FIFO occupancy in samples |
| fetched_cnt | input | 24 | Samples fetched by host so far |
| cap_en | output | 1 | Capture enable |
| outb_en | output | 1 | Memory-to-FIFO transfer enable |
| irq | output | 1 | Level interrupt |

## Verification
The case that is hardest to reach from the ports is the freeze of the status register in read request. The machine must already have passed capture and inbound transfer, and a pin that feeds status must change while the host holds off its read request. The bench reaches it by taking `mem_ready` low inside that window and reading status, which must still show the snapshot taken before entry. The out-of-order drain is reached on purpose: `outb_done` is pulsed before the host acknowledge, so the machine must remember the done. Random enables, forced stops, thresholds and counts across repeated full sequences cover the interrupt mask paths.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_CAPTURE  = 3'd1,
    ST_INB_XFER = 3'd2,
    ST_RD_REQ   = 3'd3,
    ST_FIFO_RDY = 3'd4,
    ST_DRAIN    = 3'd5,
    ST_DONE     = 3'd6
  } acq_state_e;

  localparam int A_CTRL = 0;
  localparam int A_MASK = 1;
  localparam int A_ICLR = 2;
  localparam int A_NREQ = 3;
  localparam int A_THR  = 4;
  localparam int A_STAT = 5;
  localparam int A_ACNT = 6;

  localparam int NUM_CTRL = 3;
  localparam int CB_START = 0;
  localparam int CB_RDREQ = 1;
  localparam int CB_ACK   = 2;

  localparam int NUM_IRQ   = 4;
  localparam int IS_FORCED = 0;
  localparam int IS_INB    = 1;
  localparam int IS_FIFO   = 2;
  localparam int IS_DONE   = 3;
endpackage

// File: rtl/acq_sync_edge.sv
module acq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sq;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sq[0] <= 1'b0;
        else        sq[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sq[i] <= 1'b0;
        else        sq[i] <= sq[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sq[STAGES-1];
  end

  assign rise = sq[STAGES-1] & ~prev_q;
endmodule

// File: rtl/acq_irq_ctrl.sv
module acq_irq_ctrl #(
  parameter int               N        = 4,
  parameter logic [N-1:0]     UNMASKED = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] mask,
  input  logic         clr_we,
  input  logic [N-1:0] clr_vec,
  output logic [N-1:0] pend,
  output logic         irq
);
  logic [N-1:0] keep;

  always_comb begin
    keep = pend;
    if (clr_we) keep = pend & ~clr_vec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= keep | (set_vec & (mask | UNMASKED));
  end

  assign irq = |pend;
endmodule

// File: rtl/acq_regfile.sv
module acq_regfile
  import acq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int LVL_W  = 12,
  parameter int CNT_W  = 24,
  parameter int THR_RST = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_CTRL-1:0] consume,
  output logic [NUM_CTRL-1:0] ctrl,
  output logic [NUM_IRQ-1:0]  mask,
  output logic                clr_we,
  output logic [NUM_IRQ-1:0]  clr_vec,
  output logic [CNT_W-1:0]    nreq,
  output logic [LVL_W-1:0]    thr,
  input  logic                freeze,
  input  acq_state_e          state,
  input  logic                cap_en,
  input  logic                outb_en,
  input  logic                fifo_flag,
  input  logic [NUM_IRQ-1:0]  pend,
  input  logic                mem_ready,
  input  logic [CNT_W-1:0]    act_cnt,
  output logic [DATA_W-1:0]   status
);
  localparam int STAT_PAD = DATA_W - 13;
  localparam int CNT_PAD  = DATA_W - CNT_W;

  logic w_ctrl, w_mask, w_nreq, w_thr;
  logic [NUM_CTRL-1:0] ctrl_set;
  logic unused_wdata;

  assign w_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
  assign w_mask = wr_en && (addr == ADDR_W'(A_MASK));
  assign w_nreq = wr_en && (addr == ADDR_W'(A_NREQ));
  assign w_thr  = wr_en && (addr == ADDR_W'(A_THR));
  assign clr_we = wr_en && (addr == ADDR_W'(A_ICLR));
  assign clr_vec = wdata[NUM_IRQ-1:0];
  assign ctrl_set = w_ctrl ? wdata[NUM_CTRL-1:0] : '0;
  assign unused_wdata = ^wdata[DATA_W-1:CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      mask <= '0;
      nreq <= '0;
      thr  <= LVL_W'(THR_RST);
    end else begin
      ctrl <= (ctrl & ~consume) | ctrl_set;
      if (w_mask) mask <= wdata[NUM_IRQ-1:0];
      if (w_nreq) nreq <= wdata[CNT_W-1:0];
      if (w_thr)  thr  <= wdata[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else if (!freeze)
      status <= {STAT_PAD'(0), mem_ready, pend, 2'b00, fifo_flag, outb_en, cap_en, state};
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_STAT))      rdata = status;
    else if (addr == ADDR_W'(A_ACNT)) rdata = {CNT_PAD'(0), act_cnt};
  end
endmodule

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl
  import acq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int LVL_W       = 12,
  parameter int CNT_W       = 24,
  parameter int THR_RST     = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              mem_ready,
  input  logic              hard_start,
  input  logic              cap_done,
  input  logic              cap_forced,
  input  logic              inb_done,
  input  logic              outb_done,
  input  logic [LVL_W-1:0]  ofifo_level,
  input  logic [CNT_W-1:0]  fetched_cnt,
  output logic              cap_en,
  output logic              outb_en,
  output logic              irq
);
  localparam logic [NUM_IRQ-1:0] UNMASKED = NUM_IRQ'(1) << IS_FORCED;

  acq_state_e state_q;
  logic [NUM_CTRL-1:0] ctrl, consume;
  logic [NUM_IRQ-1:0]  mask, clr_vec, pend, set_vec;
  logic                clr_we, hs_rise, fifo_flag, odone_seen;
  logic [CNT_W-1:0]    nreq, act_cnt;
  logic [LVL_W-1:0]    thr;
  logic [DATA_W-1:0]   stat_w;
  logic go, lvl_ok, drain_ok, all_fetched;

  acq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(hard_start), .rise(hs_rise));

  assign go          = (state_q == ST_IDLE) && mem_ready && ctrl[CB_START] && hs_rise;
  assign lvl_ok      = ofifo_level >= thr;
  assign drain_ok    = ctrl[CB_ACK] && (odone_seen || (outb_en && outb_done));
  assign all_fetched = fetched_cnt >= act_cnt;

  always_comb begin
    set_vec = '0;
    set_vec[IS_FORCED] = (state_q == ST_CAPTURE)  && cap_done && cap_forced;
    set_vec[IS_INB]    = (state_q == ST_INB_XFER) && inb_done;
    set_vec[IS_FIFO]   = (state_q == ST_FIFO_RDY) && lvl_ok;
    set_vec[IS_DONE]   = (state_q == ST_DONE)     && all_fetched;
    consume = '0;
    consume[CB_START] = go;
    consume[CB_RDREQ] = (state_q == ST_RD_REQ) && ctrl[CB_RDREQ];
    consume[CB_ACK]   = (state_q == ST_DRAIN)  && drain_ok;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cap_en     <= 1'b0;
      outb_en    <= 1'b0;
      fifo_flag  <= 1'b0;
      odone_seen <= 1'b0;
      act_cnt    <= '0;
    end else begin
      if (outb_en && outb_done) begin
        outb_en    <= 1'b0;
        odone_seen <= 1'b1;
      end
      case (state_q)
        ST_IDLE: begin
          odone_seen <= 1'b0;
          fifo_flag  <= 1'b0;
          if (go) begin
            state_q <= ST_CAPTURE;
            cap_en  <= 1'b1;
          end
        end
        ST_CAPTURE: if (cap_done) begin
          state_q <= ST_INB_XFER;
          cap_en  <= 1'b0;
        end
        ST_INB_XFER: if (inb_done) state_q <= ST_RD_REQ;
        ST_RD_REQ: begin
          act_cnt <= nreq;
          if (ctrl[CB_RDREQ]) begin
            state_q <= ST_FIFO_RDY;
            outb_en <= 1'b1;
          end
        end
        ST_FIFO_RDY: if (lvl_ok) begin
          state_q   <= ST_DRAIN;
          fifo_flag <= 1'b1;
        end
        ST_DRAIN: if (drain_ok) begin
          state_q   <= ST_DONE;
          fifo_flag <= 1'b0;
          outb_en   <= 1'b0;
        end
        ST_DONE: if (all_fetched) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  acq_irq_ctrl #(.N(NUM_IRQ), .UNMASKED(UNMASKED)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .mask(mask),
    .clr_we(clr_we), .clr_vec(clr_vec), .pend(pend), .irq(irq));

  acq_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W),
                .CNT_W(CNT_W), .THR_RST(THR_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .consume(consume), .ctrl(ctrl),
    .mask(mask), .clr_we(clr_we), .clr_vec(clr_vec), .nreq(nreq), .thr(thr),
    .freeze(state_q == ST_RD_REQ), .state(state_q), .cap_en(cap_en),
    .outb_en(outb_en), .fifo_flag(fifo_flag), .pend(pend),
    .mem_ready(mem_ready), .act_cnt(act_cnt), .status(stat_w));
endmodule

// File: rtl/acq_seq_ctrl_chk.sv
module acq_seq_ctrl_chk
  import acq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              mem_ready,
  input logic              cap_done,
  input logic              outb_done,
  input logic              cap_en,
  input logic              outb_en,
  input logic              irq,
  input acq_state_e        state_q,
  input logic [DATA_W-1:0] status
);
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_en) |-> $past(mem_ready)); // R2
  AST_CAP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && cap_done) |=> !cap_en); // R3
  AST_ENABLES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_en && outb_en)); // R5
  AST_OUTB_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (outb_en && outb_done) |=> !outb_en); // R7
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RD_REQ) && $past(state_q == ST_RD_REQ)) |-> $stable(status)); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_wr_en && reg_addr == ADDR_W'(A_ICLR))) |=> irq); // R10
endmodule

bind acq_seq_ctrl acq_seq_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .mem_ready(mem_ready), .cap_done(cap_done), .outb_done(outb_done),
  .cap_en(cap_en), .outb_en(outb_en), .irq(irq), .state_q(state_q),
  .status(stat_w));

// File: tb/acq_seq_ctrl_tb.sv
module acq_seq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_ready = 1'b0, hard_start = 1'b0, cap_done = 1'b0, cap_forced = 1'b0;
  logic        inb_done = 1'b0, outb_done = 1'b0;
  logic [11:0] ofifo_level = '0;
  logic [23:0] fetched_cnt = '0;
  logic        cap_en, outb_en, irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acq_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_ready(mem_ready),
    .hard_start(hard_start), .cap_done(cap_done), .cap_forced(cap_forced),
    .inb_done(inb_done), .outb_done(outb_done), .ofifo_level(ofifo_level),
    .fetched_cnt(fetched_cnt), .cap_en(cap_en), .outb_en(outb_en), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_hard();
    @(negedge clk); hard_start = 1'b1;
    tick(4);        hard_start = 1'b0;
    tick(4);
  endtask

  function automatic logic [31:0] st_code(input logic [31:0] s);
    return {29'd0, s[2:0]};
  endfunction

  function automatic logic [3:0] exp_pend(input logic [3:0] m, input bit forced, input int stage);
    logic [3:0] p;
    p = {3'b000, forced};
    if (stage >= 1) p[1] = m[1];
    if (stage >= 2) p[2] = m[2];
    if (stage >= 3) p[3] = m[3];
    return p;
  endfunction

  task automatic run_seq(input logic [3:0] m, input bit forced, input int thr, input int nreq, input bit early_done);
    logic [31:0] s;
    wr(3'd1, {28'd0, m});
    if (thr != 64) wr(3'd4, thr);
    wr(3'd0, 32'h1);
    pulse_hard();
    chk("R2 cap_en after start", cap_en, 1);
    tick(2); rd(3'd5, s);
    chk("R2 state capture", st_code(s), 1);
    tick($urandom_range(0, 12));
    @(negedge clk); cap_done = 1'b1; cap_forced = forced;
    @(negedge clk); cap_done = 1'b0; cap_forced = 1'b0;
    chk("R3 cap_en drops", cap_en, 0);
    tick(1); rd(3'd5, s);
    chk("R3 state inbound", st_code(s), 2);
    chk("R3 forced pending", {31'd0, irq}, {31'd0, forced});
    tick($urandom_range(0, 8));
    @(negedge clk); inb_done = 1'b1;
    @(negedge clk); inb_done = 1'b0;
    tick(1);
    chk("R4 irq after inbound", {31'd0, irq}, {31'd0, |exp_pend(m, forced, 1)});
    mem_ready = 1'b0;
    tick(3); rd(3'd5, s);
    chk("R9 status frozen state", st_code(s), 2);
    chk("R9 status frozen mem_ready", {31'd0, s[12]}, 1);
    mem_ready = 1'b1;
    wr(3'd3, nreq);
    tick(1);
    chk("R5 outb_en low before request", outb_en, 0);
    wr(3'd0, 32'h2);
    tick(1);
    chk("R5 outb_en", outb_en, 1);
    tick(1); rd(3'd5, s);
    chk("R5 state fifo ready", st_code(s), 4);
    rd(3'd6, s);
    chk("R5 latched count", s, nreq);
    ofifo_level = 12'(thr - 1);
    tick(3); rd(3'd5, s);
    chk("R6 below threshold waits", st_code(s), 4);
    ofifo_level = 12'(thr);
    tick(2); rd(3'd5, s);
    chk("R6 state drain", st_code(s), 5);
    chk("R6 ready flag", {31'd0, s[5]}, 1);
    chk("R6 pending fifo", {28'd0, s[11:8]}, {28'd0, exp_pend(m, forced, 2)});
    ofifo_level = '0;
    if (early_done) begin
      @(negedge clk); outb_done = 1'b1;
      @(negedge clk); outb_done = 1'b0;
      chk("R7 outb_en drops", outb_en, 0);
      tick(3); rd(3'd5, s);
      chk("R7 waits for ack", st_code(s), 5);
      wr(3'd0, 32'h4);
    end else begin
      wr(3'd0, 32'h4);
      tick(3); rd(3'd5, s);
      chk("R7 waits for done", st_code(s), 5);
      @(negedge clk); outb_done = 1'b1;
      @(negedge clk); outb_done = 1'b0;
      chk("R7 outb_en drops", outb_en, 0);
    end
    tick(2); rd(3'd5, s);
    chk("R7 state done", st_code(s), 6);
    fetched_cnt = 24'(nreq - 1);
    tick(3); rd(3'd5, s);
    chk("R8 not all fetched", st_code(s), 6);
    fetched_cnt = 24'(nreq);
    tick(3); rd(3'd5, s);
    chk("R8 back to idle", st_code(s), 0);
    chk("R8 pending done", {28'd0, s[11:8]}, {28'd0, exp_pend(m, forced, 3)});
    chk("R10 irq level", {31'd0, irq}, {31'd0, |exp_pend(m, forced, 3)});
    wr(3'd2, 32'hF);
    tick(1);
    chk("R10 irq cleared", irq, 0);
    pulse_hard();
    chk("R11 no restart", cap_en, 0);
    fetched_cnt = '0;
    if (thr != 64) wr(3'd4, 64);
  endtask

  initial begin
    logic [31:0] s;
    void'($urandom(32'd20240611));
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("R1 cap_en", cap_en, 0);
    chk("R1 outb_en", outb_en, 0);
    chk("R1 irq", irq, 0);
    rd(3'd5, s);
    chk("R1 status idle", st_code(s), 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), s);
      chk("R12 write-only reads zero", s, 0);
    end
    wr(3'd0, 32'h1);
    pulse_hard();
    chk("R2 no start without mem_ready", cap_en, 0);
    mem_ready = 1'b1;
    tick(4);
    chk("R2 no start without edge", cap_en, 0);
    wr(3'd0, 32'h0);
    run_seq(4'h0, 1'b1, 64, 1, 1'b1);
    run_seq(4'hF, 1'b0, 64, 100, 1'b0);
    for (int i = 0; i < 6; i++)
      run_seq(4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
              $urandom_range(1, 200), $urandom_range(1, 500), 1'($urandom_range(0, 1)));
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule